// File: doc/BRIEF.md
# Multilevel Resistive Cell Access Sequencer

This block controls one column of a memory whose cells each store NBITS bits as one of 2^NBITS analog resistance levels. Every access is a compound of two phases. A read senses the cell and then either restores it or, in counter mode, skips the restore. A write senses the cell and then programs it. Sensing works in three steps. The block grounds the bit line for one cycle. It then enables the word line and the load line for a programmable development time. Finally it samples a bank of 2^NBITS − 1 comparators whose references ascend.

The comparator thermometer word is reduced to a level count and then converted to Gray code. Neighbouring levels therefore differ in one bit. The program step drives a DAC selection code that joins the new data (upper half) and the sensed old data (lower half). This lets the DAC choose the voltage for that specific transition.

Each row has a disturb counter of consecutive reads. In counter mode the restore is deferred until the counter would pass a programmable limit. The analog cell, the comparators and the DAC are outside the block.

Top module: `mlc_cell_seq`

## Requirements
- R1: After an accepted request the block asserts `bl_discharge` alone for one cycle. It then asserts `wl_en` and `ll_en` together for `cfg_dev_cycles` cycles (a value of 0 acts as 1). It then asserts `wl_en` with `cmp_sample` for one cycle, with the load line off.
- R2: The sensed level is the number of asserted `cmp_therm` bits, and the reported data is that level in Gray code (level ^ level>>1). For NBITS=2, levels 0,1,2,3 read as 00, 01, 11, 10.
- R3: A comparator word in which any bit i+1 is set while bit i is clear raises `therm_err`, and the data is still taken from the count of set bits. `therm_err` keeps its value until the next sample.
- R4: With `cfg_count_mode`=0 every read follows its sample cycle with a restore step. The restore step asserts `wl_en`, `ll_en` and `ll_neg` for the development time.
- R5: With `cfg_count_mode`=1 a read restores only when the row's count plus one exceeds `cfg_rd_limit`; the count is then set to zero. Otherwise the read has no restore and the count rises by one, saturating at its maximum.
- R6: A write whose data differs from the sensed data runs a program step after the sample cycle. The step asserts `wl_en` and `dac_en` for `cfg_prog_cycles` cycles (0 acts as 1). During it `dac_code` equals {new data, sensed data}.
- R7: A write whose data equals the sensed data skips the program step. Any write, and any restore, clears that row's read counter.
- R8: `busy` is high from the cycle after acceptance through the single `done` cycle. `done` carries the sensed data on `rd_data`. Requests presented while busy are ignored and leave the cells and counters untouched.
- R9: In reset and while idle, `busy`, `done`, `bl_discharge`, `wl_en`, `ll_en`, `ll_neg`, `cmp_sample` and `dac_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_wdata | input | NBITS | Data to write |
| cfg_dev_cycles | input | TIME_W | Development and restore length in cycles |
| cfg_prog_cycles | input | TIME_W | Program step length in cycles |
| cfg_count_mode | input | 1 | 0 = restore on every read, 1 = counter-deferred restore |
| cfg_rd_limit | input | RDC_W | Read count limit for counter mode |
| cmp_therm | input | NCMP | Comparator outputs, bit 0 = lowest reference |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | NBITS | Sensed data (Gray code) |
| therm_err | output | 1 | Last sample was not a valid thermometer word |
| bl_discharge | output | 1 | Ground the bit line |
| wl_en | output | 1 | Word line enable |
| wl_row | output | ROW_W | Selected row |
| ll_en | output | 1 | Load line enable |
| ll_neg | output | 1 | Load line polarity negated (restore) |
| cmp_sample | output | 1 | Comparator sampling strobe |
| dac_en | output | 1 | Drive the DAC voltage onto the bit line |
| dac_code | output | 2*NBITS | DAC selection: {new, old} |

## Verification
A wrong phase state shows at once as a misplaced line enable in the same cycle. A miscounted phase timer stretches or shortens a pulse, and the per-cycle comparison catches it at its first extra or missing cycle. A corrupted read counter stays hidden until a later read in counter mode on the same row: that read then shows a restore step it should not have, or lacks one it should have, one cycle after its sample strobe. A wrong decode appears only on the `done` cycle, as wrong `rd_data`, or later as a wrong old-data half of `dac_code`.

// File: rtl/mlc_seq_pkg.sv
`timescale 1ns/1ps
package mlc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DISCH = 3'd1,
    PH_DEV   = 3'd2,
    PH_SAMP  = 3'd3,
    PH_REST  = 3'd4,
    PH_PROG  = 3'd5,
    PH_DONE  = 3'd6
  } phase_e;

  // binary level to reflected Gray code
  function automatic logic [7:0] lvl_to_gray(input logic [7:0] lvl);
    return lvl ^ (lvl >> 1);
  endfunction

endpackage

// File: rtl/mlc_therm_decode.sv
`timescale 1ns/1ps
module mlc_therm_decode #(
  parameter int NBITS = 2,
  localparam int NCMP = (1 << NBITS) - 1
) (
  input  logic [NCMP-1:0]  therm,
  output logic [NBITS-1:0] level,
  output logic [NBITS-1:0] data,
  output logic             nonmono
);

  function automatic logic [NBITS-1:0] count_ones(input logic [NCMP-1:0] v);
    logic [NBITS-1:0] c;
    c = '0;
    for (int i = 0; i < NCMP; i++) c = c + NBITS'(v[i]);
    return c;
  endfunction

  logic [NCMP-1:0] gap;
  logic [7:0]      gray8;

  // a set comparator above a clear one marks a broken thermometer word
  for (genvar i = 0; i < NCMP; i++) begin : g_gap
    if (i == NCMP - 1) begin : g_top
      assign gap[i] = 1'b0;
    end else begin : g_mid
      assign gap[i] = therm[i+1] & ~therm[i];
    end
  end

  assign level   = count_ones(therm);
  assign gray8   = mlc_seq_pkg::lvl_to_gray(8'(level));
  assign data    = gray8[NBITS-1:0];
  assign nonmono = |gap;

endmodule

// File: rtl/mlc_phase_timer.sv
`timescale 1ns/1ps
module mlc_phase_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] len,
  output logic              last
);

  logic [TIME_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (load)             remain <= len;
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  // a length of zero behaves as one cycle
  assign last = (remain <= TIME_W'(1));

endmodule

// File: rtl/mlc_read_tracker.sv
`timescale 1ns/1ps
module mlc_read_tracker #(
  parameter int ROWS  = 8,
  parameter int RDC_W = 6,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic             wr_en,
  input  logic [RDC_W-1:0] wr_val,
  output logic [RDC_W-1:0] cur
);

  logic [RDC_W-1:0] cnt [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt[r] <= '0;
      else if (wr_en && row == ROW_W'(r))  cnt[r] <= wr_val;
    end
  end

  always_comb begin
    cur = '0;
    for (int r = 0; r < ROWS; r++)
      if (row == ROW_W'(r)) cur = cnt[r];
  end

endmodule

// File: rtl/mlc_cell_seq.sv
`timescale 1ns/1ps
module mlc_cell_seq #(
  parameter int NBITS  = 2,
  parameter int ROWS   = 8,
  parameter int TIME_W = 8,
  parameter int RDC_W  = 6,
  localparam int NCMP  = (1 << NBITS) - 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [NBITS-1:0]   req_wdata,
  input  logic [TIME_W-1:0]  cfg_dev_cycles,
  input  logic [TIME_W-1:0]  cfg_prog_cycles,
  input  logic               cfg_count_mode,
  input  logic [RDC_W-1:0]   cfg_rd_limit,
  input  logic [NCMP-1:0]    cmp_therm,
  output logic               busy,
  output logic               done,
  output logic [NBITS-1:0]   rd_data,
  output logic               therm_err,
  output logic               bl_discharge,
  output logic               wl_en,
  output logic [ROW_W-1:0]   wl_row,
  output logic               ll_en,
  output logic               ll_neg,
  output logic               cmp_sample,
  output logic               dac_en,
  output logic [2*NBITS-1:0] dac_code
);
  import mlc_seq_pkg::*;

  phase_e ph, ph_nx;

  logic             op_write;
  logic [ROW_W-1:0] op_row;
  logic [NBITS-1:0] op_wdata;
  logic [NBITS-1:0] sensed_q;
  logic             err_q;

  logic [NBITS-1:0] dec_level, dec_data;
  logic             dec_bad;

  logic              tmr_load;
  logic [TIME_W-1:0] tmr_len;
  logic              tmr_last;

  logic [RDC_W-1:0] rd_cnt;
  logic             cnt_wr;
  logic [RDC_W-1:0] cnt_val;

  // named events for the checker
  logic accept_ev, sample_ev, need_restore, need_prog;

  mlc_therm_decode #(.NBITS(NBITS)) u_dec (
    .therm   (cmp_therm),
    .level   (dec_level),
    .data    (dec_data),
    .nonmono (dec_bad)
  );

  mlc_phase_timer #(.TIME_W(TIME_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .last  (tmr_last)
  );

  mlc_read_tracker #(.ROWS(ROWS), .RDC_W(RDC_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .row    (op_row),
    .wr_en  (cnt_wr),
    .wr_val (cnt_val),
    .cur    (rd_cnt)
  );

  assign accept_ev = (ph == PH_IDLE) && req_valid;
  assign sample_ev = (ph == PH_SAMP);
  assign need_prog = op_write && (op_wdata != dec_data);
  assign need_restore = !cfg_count_mode ||
                        ({1'b0, rd_cnt} + (RDC_W+1)'(1) > {1'b0, cfg_rd_limit});

  // counter update at the sample decision
  always_comb begin
    cnt_wr  = sample_ev;
    cnt_val = '0;
    if (!op_write && !need_restore)
      cnt_val = (rd_cnt == {RDC_W{1'b1}}) ? rd_cnt : rd_cnt + 1'b1;
  end

  always_comb begin
    ph_nx    = ph;
    tmr_load = 1'b0;
    tmr_len  = cfg_dev_cycles;
    unique case (ph)
      PH_IDLE:  if (req_valid) ph_nx = PH_DISCH;
      PH_DISCH: begin
        ph_nx    = PH_DEV;
        tmr_load = 1'b1;
      end
      PH_DEV:   if (tmr_last) ph_nx = PH_SAMP;
      PH_SAMP: begin
        if (op_write) begin
          if (need_prog) begin
            ph_nx    = PH_PROG;
            tmr_load = 1'b1;
            tmr_len  = cfg_prog_cycles;
          end else begin
            ph_nx = PH_DONE;
          end
        end else if (need_restore) begin
          ph_nx    = PH_REST;
          tmr_load = 1'b1;
        end else begin
          ph_nx = PH_DONE;
        end
      end
      PH_REST:  if (tmr_last) ph_nx = PH_DONE;
      PH_PROG:  if (tmr_last) ph_nx = PH_DONE;
      PH_DONE:  ph_nx = PH_IDLE;
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      op_write <= 1'b0;
      op_row   <= '0;
      op_wdata <= '0;
      sensed_q <= '0;
      err_q    <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (accept_ev) begin
        op_write <= req_write;
        op_row   <= req_row;
        op_wdata <= req_wdata;
      end
      if (sample_ev) begin
        sensed_q <= dec_data;
        err_q    <= dec_bad;
      end
    end
  end

  assign busy         = (ph != PH_IDLE);
  assign done         = (ph == PH_DONE);
  assign rd_data      = sensed_q;
  assign therm_err    = err_q;
  assign bl_discharge = (ph == PH_DISCH);
  assign wl_en        = (ph == PH_DEV) || (ph == PH_SAMP) ||
                        (ph == PH_REST) || (ph == PH_PROG);
  assign wl_row       = op_row;
  assign ll_en        = (ph == PH_DEV) || (ph == PH_REST);
  assign ll_neg       = (ph == PH_REST);
  assign cmp_sample   = sample_ev;
  assign dac_en       = (ph == PH_PROG);
  assign dac_code     = dac_en ? {op_wdata, sensed_q} : '0;

endmodule

// File: rtl/mlc_cell_seq_chk.sv
`timescale 1ns/1ps
module mlc_cell_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic therm_err,
  input logic bl_discharge,
  input logic wl_en,
  input logic ll_en,
  input logic ll_neg,
  input logic cmp_sample,
  input logic dac_en
);

  AST_DISCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    bl_discharge |-> !wl_en && !ll_en && !dac_en); // R1
  AST_DISCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bl_discharge); // R1
  AST_SAMPLE_AFTER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_sample |-> $past(ll_en) && !$past(ll_neg) && !ll_en); // R1
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_sample) |-> $stable(therm_err)); // R3
  AST_NEG_WITH_LL: assert property (@(posedge clk) disable iff (!rst_n)
    ll_neg |-> ll_en && wl_en); // R4
  AST_REST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ll_neg) |-> $past(cmp_sample)); // R4
  AST_DAC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_en |-> wl_en && !ll_en && !bl_discharge); // R6
  AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_en) |-> $past(cmp_sample)); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wl_en && !ll_en && !dac_en && !cmp_sample && !bl_discharge); // R9

endmodule

bind mlc_cell_seq mlc_cell_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .therm_err    (therm_err),
  .bl_discharge (bl_discharge),
  .wl_en        (wl_en),
  .ll_en        (ll_en),
  .ll_neg       (ll_neg),
  .cmp_sample   (cmp_sample),
  .dac_en       (dac_en)
);

// File: tb/sim_mlc_cell_seq.sv
`timescale 1ns/1ps
module sim_mlc_cell_seq;

  localparam int NB = 2;
  localparam int NR = 8;
  localparam int TW = 8;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]    req_row = '0;
  logic [NB-1:0] req_wdata = '0;
  logic [TW-1:0] cfg_dev_cycles = 8'd3, cfg_prog_cycles = 8'd4;
  logic          cfg_count_mode = 1'b0;
  logic [CW-1:0] cfg_rd_limit = 6'd2;
  logic [2:0]    cmp_therm = '0;
  logic          busy, done, therm_err, bl_discharge, wl_en, ll_en, ll_neg, cmp_sample, dac_en;
  logic [NB-1:0] rd_data;
  logic [2:0]    wl_row;
  logic [3:0]    dac_code;

  mlc_cell_seq #(.NBITS(NB), .ROWS(NR), .TIME_W(TW), .RDC_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_wdata(req_wdata), .cfg_dev_cycles(cfg_dev_cycles),
    .cfg_prog_cycles(cfg_prog_cycles), .cfg_count_mode(cfg_count_mode),
    .cfg_rd_limit(cfg_rd_limit), .cmp_therm(cmp_therm), .busy(busy), .done(done),
    .rd_data(rd_data), .therm_err(therm_err), .bl_discharge(bl_discharge),
    .wl_en(wl_en), .wl_row(wl_row), .ll_en(ll_en), .ll_neg(ll_neg),
    .cmp_sample(cmp_sample), .dac_en(dac_en), .dac_code(dac_code)
  );

  typedef struct packed {
    logic busy, done, bl, wl, ll, neg, samp, dac;
    logic [3:0] code;
    logic [1:0] rd;
    logic err;
    logic [2:0] row;
  } vec_t;

  vec_t  q[$];
  string tq[$];
  int    vectors = 0, miscompares = 0;
  int    cell_lvl [NR];
  int    rd_count [NR];
  bit    finished = 1'b0;

  function automatic logic [1:0] gray_of(int n);
    case (n)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int level_of(logic [1:0] g);
    case (g)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic push(vec_t v, string tag);
    q.push_back(v);
    tq.push_back(tag);
  endtask

  task automatic check_now();
    vec_t e;
    string t;
    bit ok;
    if (q.size() > 0) begin
      e = q.pop_front();
      t = tq.pop_front();
    end else begin
      e = '0;
      t = "R9";
    end
    vectors++;
    ok = (busy == e.busy) && (done == e.done) && (bl_discharge == e.bl) &&
         (wl_en == e.wl) && (ll_en == e.ll) && (ll_neg == e.neg) &&
         (cmp_sample == e.samp) && (dac_en == e.dac) &&
         (!e.dac || dac_code == e.code) &&
         (!e.done || (rd_data == e.rd && therm_err == e.err)) &&
         (!e.wl || wl_row == e.row);
    if (!ok) begin
      miscompares++;
      $display("FAIL %s t=%0t got b%b d%b bl%b wl%b ll%b ng%b s%b dac%b code%h rd%b err%b row%0d exp b%b d%b bl%b wl%b ll%b ng%b s%b dac%b code%h rd%b err%b row%0d",
               t, $time, busy, done, bl_discharge, wl_en, ll_en, ll_neg, cmp_sample, dac_en,
               dac_code, rd_data, therm_err, wl_row,
               e.busy, e.done, e.bl, e.wl, e.ll, e.neg, e.samp, e.dac, e.code, e.rd, e.err, e.row);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check_now();
  endtask

  // builds the expected per-cycle schedule of one operation and runs it
  task automatic run_op(bit wr, int row, logic [1:0] wdata, bit force_th, logic [2:0] fth,
                        string tag, bit intrude);
    vec_t v;
    logic [2:0] th;
    int ones, d, p;
    bit err;
    logic [1:0] sensed;
    th = '0;
    for (int i = 0; i < 3; i++) th[i] = (cell_lvl[row] > i);
    if (force_th) th = fth;
    ones = 0;
    for (int i = 0; i < 3; i++) if (th[i]) ones++;
    err = !(th == 3'b000 || th == 3'b001 || th == 3'b011 || th == 3'b111);
    sensed = gray_of(ones);
    d = (cfg_dev_cycles == 0) ? 1 : int'(cfg_dev_cycles);
    p = (cfg_prog_cycles == 0) ? 1 : int'(cfg_prog_cycles);

    v = '0; v.row = 3'(row); v.busy = 1'b1; v.bl = 1'b1;
    push(v, "R1");
    v.bl = 1'b0; v.wl = 1'b1; v.ll = 1'b1;
    for (int i = 0; i < d; i++) push(v, "R1");
    v.ll = 1'b0; v.samp = 1'b1;
    push(v, "R1");
    v.samp = 1'b0;
    if (wr) begin
      if (wdata != sensed) begin
        v.dac = 1'b1; v.code = {wdata, sensed};
        for (int i = 0; i < p; i++) push(v, "R6");
        v.dac = 1'b0;
        cell_lvl[row] = level_of(wdata);
      end
      rd_count[row] = 0;
    end else begin
      if (!cfg_count_mode || rd_count[row] + 1 > int'(cfg_rd_limit)) begin
        v.ll = 1'b1; v.neg = 1'b1;
        for (int i = 0; i < d; i++) push(v, cfg_count_mode ? "R5" : "R4");
        v.ll = 1'b0; v.neg = 1'b0;
        rd_count[row] = 0;
      end else if (rd_count[row] < 63) begin
        rd_count[row]++;
      end
    end
    v.wl = 1'b0; v.done = 1'b1; v.rd = sensed; v.err = err;
    push(v, tag);

    req_valid = 1'b1; req_write = wr; req_row = 3'(row); req_wdata = wdata; cmp_therm = th;
    tick();
    req_valid = 1'b0;
    if (intrude) begin
      // R8: a write presented while busy must change nothing
      tick();
      req_valid = 1'b1; req_write = 1'b1; req_row = 3'd5; req_wdata = 2'b10;
      tick();
      tick();
      req_valid = 1'b0;
    end
    while (q.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R8 watchdog expired, got busy=%b expected idle", busy);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      cell_lvl[r] = 0;
      rd_count[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();                                   // R9 idle after reset

    run_op(1'b1, 1, 2'b11, 1'b0, 3'b0, "R6", 1'b0);      // program 00 -> 11
    run_op(1'b0, 1, 2'b00, 1'b0, 3'b0, "R2", 1'b0);      // read level 2 -> 11, R4 restore
    run_op(1'b1, 2, 2'b10, 1'b0, 3'b0, "R6", 1'b0);
    run_op(1'b0, 2, 2'b00, 1'b0, 3'b0, "R2", 1'b0);      // level 3 -> 10
    run_op(1'b1, 3, 2'b01, 1'b0, 3'b0, "R6", 1'b0);
    run_op(1'b0, 3, 2'b00, 1'b0, 3'b0, "R2", 1'b0);      // level 1 -> 01
    run_op(1'b0, 0, 2'b00, 1'b0, 3'b0, "R2", 1'b0);      // level 0 -> 00
    run_op(1'b1, 1, 2'b11, 1'b0, 3'b0, "R7", 1'b0);      // same data: no program

    cfg_dev_cycles = 8'd0;                               // R1 zero acts as one
    run_op(1'b0, 2, 2'b00, 1'b0, 3'b0, "R1", 1'b0);
    cfg_prog_cycles = 8'd1;
    run_op(1'b1, 2, 2'b00, 1'b0, 3'b0, "R6", 1'b0);      // 10 -> 00, code 0010
    run_op(1'b0, 2, 2'b00, 1'b0, 3'b0, "R2", 1'b0);
    cfg_dev_cycles = 8'd2;

    run_op(1'b0, 4, 2'b00, 1'b1, 3'b101, "R3", 1'b0);    // 2 ones -> 11, err
    run_op(1'b0, 4, 2'b00, 1'b1, 3'b010, "R3", 1'b0);    // 1 one  -> 01, err
    run_op(1'b0, 4, 2'b00, 1'b1, 3'b100, "R3", 1'b0);
    run_op(1'b0, 4, 2'b00, 1'b0, 3'b0,   "R3", 1'b0);    // clean word clears err
    run_op(1'b1, 4, 2'b10, 1'b1, 3'b110, "R3", 1'b0);    // old data from count: 11

    run_op(1'b0, 3, 2'b00, 1'b0, 3'b0, "R8", 1'b1);      // intruding request ignored
    run_op(1'b0, 5, 2'b00, 1'b0, 3'b0, "R8", 1'b0);      // row 5 still level 0

    cfg_count_mode = 1'b1;
    cfg_rd_limit = 6'd2;
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // count 1, no restore
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // count 2
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // 3 > 2: restore, cleared
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // count 1
    run_op(1'b1, 6, 2'b00, 1'b0, 3'b0, "R7", 1'b0);      // skipped write clears count
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R7", 1'b0);
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R7", 1'b0);
    run_op(1'b0, 6, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // restore again
    cfg_rd_limit = 6'd0;
    run_op(1'b0, 7, 2'b00, 1'b0, 3'b0, "R5", 1'b0);      // limit 0: every read restores
    run_op(1'b0, 7, 2'b00, 1'b0, 3'b0, "R5", 1'b0);

    repeat (2) tick();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule